// File: doc/BRIEF.md
# LIN Frame Transmit Sequencer

This block sits between a host-side write port and a byte-level serial transmitter, and turns a stream of host byte writes into one LIN frame. The host writes every byte of a frame into one transmit register. The first few bytes configure the frame:

- an identifier, which is sent with optional protected-identifier parity;
- a length;
- an options byte;
- for receive-direction frames only, a timeout byte.

These configuration bytes are consumed, not sent, apart from the identifier. The data bytes that follow go out unchanged. The CRC-16 and checksum trailers selected in the options byte are then appended without any further host writes.

Output bytes leave through a valid/ready handshake, one byte in flight at a time. Bit-level framing, break and sync generation happen downstream. The downstream transmitter reports bit errors back. A bit error aborts the frame and locks out host writes until the host clears the error flag. A flush input discards a partly written frame. A frame-complete flag, with its interrupt enable, marks the point where every byte of the frame has been handed over.

Top module: `linframe_tx_seq`

## Requirements
- R1: A host write (`host_wr` high) made while `tx_ready` is low is ignored. It sends nothing and counts toward nothing in the frame. `tx_ready` is low while a data or identifier byte is still waiting on the output, during trailer emission, and while the error flag is set.
- R2: The first byte of a frame is the identifier and is the first byte sent on the output. The second byte (length) and the third byte (options) are never sent.
- R3: Options bit 0 selects the direction, with 1 meaning transmit. A transmit frame takes no timeout byte, and the byte written after the options byte is its first data byte. A receive frame (bit 0 = 0) consumes one timeout byte and then completes after sending only the identifier.
- R4: With `par_en` high, the sent identifier is {P1, P0, ID[5:0]}, where P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5). With `par_en` low, the first byte is sent unchanged.
- R5: A transmit frame accepts exactly as many data bytes as the length byte gives, including zero, and sends them in write order.
- R6: Options bit 2 appends a CRC-16 over the data bytes. It uses polynomial 0x1021, starts from 0xFFFF, runs MSB first and is sent high byte first. Options bit 1 appends, after any CRC, the inverted 8-bit end-around-carry sum of the data bytes.
- R7: A `bit_err` pulse aborts the frame, drops any pending output byte and sets `err_flag`. `tx_ready` stays low until `err_clr`. The next byte written after that starts a new frame as its identifier.
- R8: A `flush` pulse discards the partly written frame and any pending output byte, and returns to waiting for an identifier. It does not touch `err_flag`.
- R9: `done_flag` sets once the last byte of a frame has been accepted downstream, and clears on `done_clr`. `done_irq` equals `done_flag` gated by `done_ie`.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady, unless an abort or a flush intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the transmit register |
| host_data | input | 8 | Byte written by the host |
| tx_ready | output | 1 | Host may write a byte this cycle |
| par_en | input | 1 | Insert identifier parity bits |
| flush | input | 1 | Discard the current frame |
| bit_err | input | 1 | Bit error reported by the byte transmitter |
| err_clr | input | 1 | Clear the error flag |
| done_clr | input | 1 | Clear the frame-complete flag |
| done_ie | input | 1 | Frame-complete interrupt enable |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Byte transmitter accepts the byte |
| err_flag | output | 1 | Bit error occurred, frame aborted |
| done_flag | output | 1 | Frame complete |
| done_irq | output | 1 | Frame-complete interrupt |

## Verification
The hardest case to reach from the ports is a host write that arrives while `tx_ready` is low in the middle of a data phase. That state exists only while the output byte is stalled. The bench gets there by switching its randomly stalling sink off entirely, writing the header and options, and then forcing the write strobe while the identifier is still pending. It then checks that the finished frame carries exactly the requested data bytes and a checksum over them alone. Aborts and flushes are likewise injected with the sink paused, so that the dropped byte and the restart on a fresh identifier can be observed unambiguously.

// File: rtl/linseq_pkg.sv
package linseq_pkg;

    localparam int BYTE_W      = 8;
    localparam int CRC_W       = 16;
    localparam int OPT_W       = 3;
    localparam int OPT_DIR_BIT = 0;
    localparam int OPT_CKS_BIT = 1;
    localparam int OPT_CRC_BIT = 2;

    typedef enum logic [3:0] {
        ST_ID,
        ST_LEN,
        ST_OPT,
        ST_TMO,
        ST_DATA,
        ST_CRCH,
        ST_CRCL,
        ST_CKS,
        ST_FIN
    } seq_st_e;

    typedef struct packed {
        seq_st_e             st;
        logic [BYTE_W-1:0]   len;
        logic [BYTE_W-1:0]   cnt;
        logic [OPT_W-1:0]    opt;
        logic                ov;
        logic [BYTE_W-1:0]   od;
        logic                err;
        logic                done;
    } seq_regs_t;

    // One byte of a left-shifting CRC, data folded into the top byte.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic [CRC_W-1:0] poly);
        logic [CRC_W-1:0] x;
        x = c ^ {b, {(CRC_W-BYTE_W){1'b0}}};
        for (int i = 0; i < BYTE_W; i++) begin
            x = x[CRC_W-1] ? ((x << 1) ^ poly) : (x << 1);
        end
        return x;
    endfunction

    // Sum with the carry folded back into bit 0.
    function automatic logic [BYTE_W-1:0] cks_step(input logic [BYTE_W-1:0] s,
                                                   input logic [BYTE_W-1:0] b);
        logic [BYTE_W:0] t;
        t = {1'b0, s} + {1'b0, b};
        return t[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, t[BYTE_W]};
    endfunction

    // Trailer state that follows the last data byte.
    function automatic seq_st_e after_data(input logic [OPT_W-1:0] o);
        if (o[OPT_CRC_BIT])      return ST_CRCH;
        else if (o[OPT_CKS_BIT]) return ST_CKS;
        else                     return ST_FIN;
    endfunction

endpackage

// File: rtl/linseq_idfmt.sv
module linseq_idfmt
    import linseq_pkg::*;
(
    input  logic [BYTE_W-1:0] raw,
    input  logic              par_en,
    output logic [BYTE_W-1:0] id_out
);
    logic p0;
    logic p1;

    always_comb begin
        p0 = raw[0] ^ raw[1] ^ raw[2] ^ raw[4];
        p1 = ~(raw[1] ^ raw[3] ^ raw[4] ^ raw[5]);
        id_out = par_en ? {p1, p0, raw[5:0]} : raw;
    end

endmodule

// File: rtl/linseq_crc.sv
module linseq_crc
    import linseq_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 16'h1021,
    parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr)      crc_d = INIT;
        else if (upd) crc_d = crc_step(crc_q, din, POLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    // R6: a cleared accumulator restarts from the initial value
    a_r6_crc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == INIT));

endmodule

// File: rtl/linseq_cksum.sv
module linseq_cksum
    import linseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] sum
);
    logic [BYTE_W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr)      sum_d = '0;
        else if (upd) sum_d = cks_step(sum_q, din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;

    // R6: a cleared sum starts at zero
    a_r6_sum_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum == '0));

endmodule

// File: rtl/linframe_tx_seq.sv
module linframe_tx_seq
    import linseq_pkg::*;
#(
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
    parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_data,
    output logic              tx_ready,
    input  logic              par_en,
    input  logic              flush,
    input  logic              bit_err,
    input  logic              err_clr,
    input  logic              done_clr,
    input  logic              done_ie,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic              err_flag,
    output logic              done_flag,
    output logic              done_irq
);
    seq_regs_t         r_d, r_q;
    logic              acc_clr;
    logic              acc_upd;
    logic              accept;
    logic [BYTE_W-1:0] id_byte;
    logic [CRC_W-1:0]  crc_val;
    logic [BYTE_W-1:0] sum_val;
    logic [BYTE_W-1:0] cnt_inc;

    linseq_idfmt u_idfmt (
        .raw    (host_data),
        .par_en (par_en),
        .id_out (id_byte)
    );

    linseq_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .upd   (acc_upd),
        .din   (host_data),
        .crc   (crc_val)
    );

    linseq_cksum u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .upd   (acc_upd),
        .din   (host_data),
        .sum   (sum_val)
    );

    // Ready depends only on registered state.
    always_comb begin
        tx_ready = 1'b0;
        if (!r_q.err) begin
            unique case (r_q.st)
                ST_LEN, ST_OPT, ST_TMO: tx_ready = 1'b1;
                ST_ID, ST_DATA:         tx_ready = !r_q.ov;
                default:                tx_ready = 1'b0;
            endcase
        end
    end

    assign accept  = host_wr && tx_ready;
    assign cnt_inc = r_q.cnt + 8'd1;

    always_comb begin
        r_d     = r_q;
        acc_clr = 1'b0;
        acc_upd = 1'b0;

        if (r_q.ov && out_ready) r_d.ov = 1'b0;
        if (done_clr)            r_d.done = 1'b0;
        if (err_clr)             r_d.err = 1'b0;

        unique case (r_q.st)
            ST_ID: if (accept) begin
                r_d.od  = id_byte;
                r_d.ov  = 1'b1;
                r_d.st  = ST_LEN;
                acc_clr = 1'b1;
            end
            ST_LEN: if (accept) begin
                r_d.len = host_data;
                r_d.st  = ST_OPT;
            end
            ST_OPT: if (accept) begin
                r_d.opt = host_data[OPT_W-1:0];
                r_d.cnt = '0;
                if (!host_data[OPT_DIR_BIT])
                    r_d.st = ST_TMO;
                else if (r_q.len == '0)
                    r_d.st = after_data(host_data[OPT_W-1:0]);
                else
                    r_d.st = ST_DATA;
            end
            ST_TMO: if (accept) begin
                r_d.st = ST_FIN;
            end
            ST_DATA: if (accept) begin
                r_d.od  = host_data;
                r_d.ov  = 1'b1;
                r_d.cnt = cnt_inc;
                acc_upd = 1'b1;
                if (cnt_inc == r_q.len) r_d.st = after_data(r_q.opt);
            end
            ST_CRCH: if (!r_q.ov) begin
                r_d.od = crc_val[CRC_W-1:BYTE_W];
                r_d.ov = 1'b1;
                r_d.st = ST_CRCL;
            end
            ST_CRCL: if (!r_q.ov) begin
                r_d.od = crc_val[BYTE_W-1:0];
                r_d.ov = 1'b1;
                r_d.st = r_q.opt[OPT_CKS_BIT] ? ST_CKS : ST_FIN;
            end
            ST_CKS: if (!r_q.ov) begin
                r_d.od = ~sum_val;
                r_d.ov = 1'b1;
                r_d.st = ST_FIN;
            end
            ST_FIN: if (!r_q.ov) begin
                r_d.done = 1'b1;
                r_d.st   = ST_ID;
            end
            default: r_d.st = ST_ID;
        endcase

        if (bit_err) begin
            r_d.err = 1'b1;
            r_d.st  = ST_ID;
            r_d.ov  = 1'b0;
            acc_clr = 1'b1;
        end
        if (flush) begin
            r_d.st  = ST_ID;
            r_d.ov  = 1'b0;
            acc_clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_ID, len: '0, cnt: '0, opt: '0, ov: 1'b0,
                     od: '0, err: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.ov;
    assign out_data  = r_q.od;
    assign err_flag  = r_q.err;
    assign done_flag = r_q.done;
    assign done_irq  = r_q.done & done_ie;

    // R7: host is locked out while an error is pending
    a_r7_err_locks: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !tx_ready);

    // R10: a stalled output byte holds steady
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !bit_err && !flush)
            |=> (out_valid && $stable(out_data)));

    // R8: flush lands in the identifier state with nothing pending
    a_r8_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (r_q.st == ST_ID && !out_valid));

    // R9: frame complete only when the output has drained
    a_r9_done_drained: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> !out_valid);

    // R1: a refused write in the data phase does not advance the count
    a_r1_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DATA && host_wr && !tx_ready && !bit_err && !flush)
            |=> $stable(r_q.cnt));

endmodule

// File: tb/sim_linframe_tx_seq.sv
module sim_linframe_tx_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       tx_ready;
    logic       par_en = 1'b1;
    logic       flush = 1'b0;
    logic       bit_err = 1'b0;
    logic       err_clr = 1'b0;
    logic       done_clr = 1'b0;
    logic       done_ie = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;
    logic       err_flag;
    logic       done_flag;
    logic       done_irq;

    int tests = 0;
    int fails = 0;
    bit sink_en = 1'b1;
    logic [7:0] got[$];
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    linframe_tx_seq u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
        .tx_ready(tx_ready), .par_en(par_en), .flush(flush), .bit_err(bit_err),
        .err_clr(err_clr), .done_clr(done_clr), .done_ie(done_ie),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .err_flag(err_flag), .done_flag(done_flag), .done_irq(done_irq)
    );

    function automatic logic [7:0] m_id(input logic [7:0] b, input logic pe);
        logic a, c;
        a = b[0] ^ b[1] ^ b[2] ^ b[4];
        c = ~(b[1] ^ b[3] ^ b[4] ^ b[5]);
        return pe ? {c, a, b[5:0]} : b;
    endfunction

    function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [7:0] d);
        logic fb;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic logic [7:0] m_sum(input logic [7:0] s, input logic [7:0] d);
        logic [8:0] t;
        t = s + d;
        if (t[8]) t = t[7:0] + 9'd1;
        return t[7:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Sink with random stalls.
    initial begin
        forever begin
            @(negedge clk);
            out_ready = sink_en && ($urandom % 4 != 0);
            if (out_valid && out_ready) got.push_back(out_data);
        end
    end

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        host_wr   = 1'b1;
        host_data = b;
        @(negedge clk);
        host_wr   = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            if (done_flag) break;
            @(negedge clk);
        end
    endtask

    task automatic compare_seq(input string req);
        bit ok;
        ok = (got.size() == exp_q.size());
        if (ok) foreach (exp_q[i]) if (got[i] !== exp_q[i]) ok = 1'b0;
        check(ok, req, "byte sequence (size/first)", {got.size(), (got.size() > 0) ? got[0] : 8'h00},
              {exp_q.size(), (exp_q.size() > 0) ? exp_q[0] : 8'h00});
    endtask

    task automatic clear_done();
        pulse(done_clr);
        @(negedge clk);
        check(done_flag == 1'b0, "R9", "done cleared", done_flag, 0);
    endtask

    // Builds the expected transmit frame and writes it.
    task automatic run_frame(input logic [7:0] id, input int len, input logic [2:0] opt,
                             input logic pe, input string req);
        logic [7:0]  d;
        logic [15:0] c = 16'hFFFF;
        logic [7:0]  s = 8'h00;
        got.delete();
        exp_q.delete();
        par_en = pe;
        exp_q.push_back(m_id(id, pe));
        wr(id);
        wr(len[7:0]);
        wr({5'b0, opt});
        for (int i = 0; i < len; i++) begin
            d = $urandom;
            exp_q.push_back(d);
            c = m_crc(c, d);
            s = m_sum(s, d);
            wr(d);
        end
        if (opt[2]) begin
            exp_q.push_back(c[15:8]);
            exp_q.push_back(c[7:0]);
        end
        if (opt[1]) exp_q.push_back(~s);
        wait_done();
        check(done_flag == 1'b1, "R9", "done after frame", done_flag, 1);
        compare_seq(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R9: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_ready == 1'b1 && out_valid == 1'b0 && done_flag == 1'b0 && err_flag == 1'b0,
              "R2", "reset state", {tx_ready, out_valid, done_flag, err_flag}, 4'b1000);

        // R4/R6 directed: parity on, CRC and checksum over known data
        run_frame(8'h3C, 3, 3'b111, 1'b1, "R6");
        clear_done();
        // R4: parity off sends the raw byte
        run_frame(8'hC5, 1, 3'b001, 1'b0, "R4");
        clear_done();
        // R5: zero-length frame with both trailers
        run_frame(8'h11, 0, 3'b111, 1'b1, "R5");
        clear_done();

        // R9: interrupt follows the enable
        done_ie = 1'b1;
        run_frame(8'h2A, 2, 3'b011, 1'b1, "R3");
        check(done_irq == 1'b1, "R9", "irq enabled", done_irq, 1);
        done_ie = 1'b0;
        @(negedge clk);
        check(done_irq == 1'b0, "R9", "irq masked", done_irq, 0);
        clear_done();

        // R3: receive frame consumes timeout byte, sends only identifier
        got.delete();
        exp_q.delete();
        par_en = 1'b1;
        exp_q.push_back(m_id(8'h3A, 1'b1));
        wr(8'h3A); wr(8'd5); wr(8'h00); wr(8'h20);
        wait_done();
        check(done_flag == 1'b1, "R3", "receive frame done", done_flag, 1);
        compare_seq("R3");
        clear_done();

        // R1: write while not ready is dropped
        got.delete();
        exp_q.delete();
        sink_en = 1'b0;
        repeat (2) @(negedge clk);
        begin
            logic [7:0] d0, d1;
            d0 = 8'h81; d1 = 8'hF0;
            exp_q.push_back(m_id(8'h07, 1'b1));
            wr(8'h07); wr(8'd2); wr(8'h03);
            @(negedge clk);
            check(tx_ready == 1'b0, "R1", "not ready while id pending", tx_ready, 0);
            host_wr = 1'b1; host_data = 8'h55;
            repeat (2) @(negedge clk);
            host_wr = 1'b0;
            sink_en = 1'b1;
            wr(d0); wr(d1);
            exp_q.push_back(d0);
            exp_q.push_back(d1);
            exp_q.push_back(~m_sum(m_sum(8'h00, d0), d1));
            wait_done();
            compare_seq("R1");
            clear_done();
        end

        // R10: a stalled byte holds
        sink_en = 1'b0;
        repeat (2) @(negedge clk);
        got.delete();
        wr(8'h15);
        @(negedge clk);
        begin
            logic [7:0] held;
            held = out_data;
            repeat (4) @(negedge clk);
            check(out_valid == 1'b1 && out_data == held, "R10", "stalled byte held",
                  out_data, held);
        end

        // R7: bit error aborts and locks out the host
        wr(8'd4); wr(8'h01);
        pulse(bit_err);
        check(err_flag == 1'b1 && out_valid == 1'b0 && tx_ready == 1'b0, "R7",
              "abort state", {err_flag, out_valid, tx_ready}, 3'b100);
        repeat (5) @(negedge clk);
        check(tx_ready == 1'b0, "R7", "still locked", tx_ready, 0);
        pulse(err_clr);
        check(tx_ready == 1'b1 && err_flag == 1'b0, "R7", "released", {tx_ready, err_flag}, 2'b10);
        sink_en = 1'b1;
        run_frame(8'h21, 2, 3'b101, 1'b1, "R7");
        clear_done();

        // R8: flush mid-frame
        sink_en = 1'b0;
        repeat (2) @(negedge clk);
        wr(8'h09); wr(8'd3); wr(8'h03);
        pulse(flush);
        check(out_valid == 1'b0 && tx_ready == 1'b1 && err_flag == 1'b0 && done_flag == 1'b0,
              "R8", "flushed", {out_valid, tx_ready, err_flag, done_flag}, 4'b0100);
        sink_en = 1'b1;
        run_frame(8'h0E, 3, 3'b110 | 3'b001, 1'b1, "R8");
        clear_done();

        // Random frames
        for (int k = 0; k < 20; k++) begin
            logic [7:0] rid;
            int         rlen;
            logic [2:0] ropt;
            rid  = $urandom;
            rlen = $urandom % 9;
            ropt = 3'b001 | (3'($urandom) & 3'b110);
            run_frame(rid, rlen, ropt, 1'($urandom), "R5");
            clear_done();
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule